// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is the tag-and-control part of a set-associative cache placed between an upstream requester (a processor core or an inner cache level) and a downstream level (another cache or main memory). Each upstream request carries a byte address and a read/write flag. The controller splits the address into tag, set and offset fields. It looks the tag up in the selected set and answers with a one-cycle response that reports hit or miss. Data payload is not stored: the block keeps only tags, valid bits, dirty bits and replacement state.

Writes that hit stay local and only mark the line dirty. Any miss, read or write, allocates the line. If every way of the set is occupied, a victim is chosen by the replacement policy fixed at build time, either true LRU or tree pseudo-LRU. A dirty victim is written back to the downstream level as a whole block, and only then is the demand block read. The controller serves one request at a time and holds the upstream side stalled until the miss has been filled. Single-cycle event pulses mark hits, misses, writebacks and fill reads, so that performance counters outside the block can count them.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `up_ready` is 1, `rsp_valid` and `dn_req_valid` are 0, and the first access to any address reports a miss.
- R2: A read whose tag matches a valid way of its set answers with `rsp_hit`=1 and issues no downstream request.
- R3: A write hit answers with `rsp_hit`=1, issues no downstream request and marks the line dirty. The dirty line is written back when it is later evicted.
- R4: A read miss issues exactly one downstream read (`dn_req_write`=0) whose block address is the request address shifted right by the offset width (tag above set). It then answers with `rsp_hit`=0, and the next read of that block hits.
- R5: A write miss allocates the block exactly as a read miss does. The new line is dirty, so its later eviction produces a writeback.
- R6: While the set holds an invalid way, a miss fills the lowest-numbered invalid way and evicts nothing. Filling all ways of an empty set therefore leaves every filled block resident.
- R7: When the victim is dirty, the downstream write of the victim's block address (victim tag above set) is issued before the read of the demand block, and the two are adjacent.
- R8: With `POLICY`=0 (true LRU), the victim is the way touched least recently, where both hits and fills count as touches.
- R9: With `POLICY`=1 (tree pseudo-LRU, one bit per internal node, 0 steering to the lower half), each touch sets the nodes on its path to point away from it. The victim is found by walking the bits from the root.
- R10: Sets are independent: the set index is address bits [OFF_W+SET_W-1:OFF_W], and a miss in one set leaves the lines of other sets resident.
- R11: `up_ready` is 1 only when idle. From acceptance until the response pulse, no new request is accepted.
- R12: `ev_hit`, `ev_miss`, `ev_wb` and `ev_fill` are single-cycle pulses. Each fires exactly once per hit, miss, accepted writeback and accepted fill read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_write | input | 1 | 1 = write request, 0 = read |
| up_addr | input | ADDR_W | Byte address of the request |
| up_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response was a hit (valid with rsp_valid) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_write | output | 1 | 1 = block writeback, 0 = block read |
| dn_req_addr | output | ADDR_W-OFF_W | Downstream block address |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_rd_done | input | 1 | Downstream read has completed |
| ev_hit | output | 1 | Hit event pulse |
| ev_miss | output | 1 | Miss event pulse |
| ev_wb | output | 1 | Writeback issued pulse |
| ev_fill | output | 1 | Fill read issued pulse |

## Verification
The hardest situation to reach from the ports is a dirty victim under a known replacement order. It needs a full set, a specific way made dirty earlier and then left untouched, and a recency order in which that way ends up oldest. The stimulus fills one set from empty, dirties a chosen block with a write hit or a write miss, re-touches the other residents in a planned order, and then misses with a new tag. The same stream drives an LRU instance and a pseudo-LRU instance side by side, and one later access hits in one policy and misses in the other.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_WAIT
  } wbc_state_e;

  localparam int POL_LRU  = 0;
  localparam int POL_PLRU = 1;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
  input  logic [SET_W-1:0]            look_set,
  output logic [WAYS-1:0]             valid_row,
  output logic [WAYS-1:0]             dirty_row,
  input  logic                        mark_dirty,
  input  logic [WAY_W-1:0]            mark_way,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        fill_dirty
);
  logic [TAG_W-1:0] rd_q [WAYS];
  logic [WAYS-1:0]  vld [SETS];
  logic [WAYS-1:0]  drt [SETS];

  // one tag RAM per way, synchronous read, so each maps to block RAM
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (fill_en && fill_way == WAY_W'(w)) mem[look_set] <= fill_tag;
      if (rd_en) rd_q[w] <= mem[rd_set];
    end
    assign rd_tags[w] = rd_q[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        drt[s] <= '0;
      end
    end else begin
      if (fill_en) begin
        vld[look_set][fill_way] <= 1'b1;
        drt[look_set][fill_way] <= fill_dirty;
      end
      if (mark_dirty) drt[look_set][mark_way] <= 1'b1;
    end
  end

  assign valid_row = vld[look_set];
  assign dirty_row = drt[look_set];

  // R6
  fill_invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !(&valid_row)) |-> !valid_row[fill_way]);
endmodule

// File: rtl/wbc_repl.sv
module wbc_repl #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int POLICY = 0,
  parameter int SET_W  = 4,
  parameter int WAY_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  import wbc_pkg::*;

  if (WAYS == 1) begin : g_dm
    assign victim = '0;
  end else if (POLICY == POL_PLRU) begin : g_plru
    localparam int LV = $clog2(WAYS);
    logic [WAYS-2:0] tr [SETS];
    logic [WAYS-2:0] nxt_tr;
    logic [LV:0]     vnode;
    logic [LV:0]     unode;

    always_comb begin
      vnode = '0;
      for (int l = 0; l < LV; l++)
        vnode = (vnode << 1) + (LV+1)'(1) + (LV+1)'(tr[set_i][vnode]);
      victim = WAY_W'(vnode - (LV+1)'(WAYS-1));
    end

    always_comb begin
      nxt_tr = tr[set_i];
      unode  = '0;
      for (int l = 0; l < LV; l++) begin
        nxt_tr[unode] = ~touch_way[LV-1-l];
        unode = (unode << 1) + (LV+1)'(1) + (LV+1)'(touch_way[LV-1-l]);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < SETS; s++) tr[s] <= '0;
      end else if (touch_en) begin
        tr[set_i] <= nxt_tr;
      end
    end
  end else begin : g_lru
    logic [WAY_W-1:0] age [SETS][WAYS];
    logic [WAYS-1:0]  oldest;

    always_comb begin
      victim = '0;
      oldest = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (age[set_i][w] == WAY_W'(WAYS-1)) begin
          victim    = WAY_W'(w);
          oldest[w] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) age[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way) age[set_i][w] <= '0;
          else if (age[set_i][w] < age[set_i][touch_way])
            age[set_i][w] <= age[set_i][w] + 1'b1;
        end
      end
    end

    // R8
    lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(oldest) == 1);
  end

  if (WAYS > 1) begin : g_away
    // R9
    victim_not_touched_chk: assert property (@(posedge clk) disable iff (rst)
      touch_en |=> (set_i != $past(set_i) || victim != $past(touch_way)));
  end
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int POLICY      = 0,
  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS),
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int SET_W = wbc_pkg::idx_bits(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W,
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int WAY_W = wbc_pkg::idx_bits(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              up_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              dn_req_valid,
  output logic              dn_req_write,
  output logic [BLK_W-1:0]  dn_req_addr,
  input  logic              dn_req_ready,
  input  logic              dn_rd_done,
  output logic              ev_hit,
  output logic              ev_miss,
  output logic              ev_wb,
  output logic              ev_fill
);
  import wbc_pkg::*;

  wbc_state_e state;
  logic [TAG_W-1:0] req_tag, wb_tag_q;
  logic [SET_W-1:0] req_set;
  logic             req_wr;
  logic [WAY_W-1:0] way_q;

  logic [WAYS-1:0][TAG_W-1:0] rd_tags;
  logic [WAYS-1:0] valid_row, dirty_row, hit_vec;
  logic            hit, any_inv, need_wb;
  logic [WAY_W-1:0] hit_way, inv_way, victim, alloc_way, touch_way;
  logic            touch_en, fill_en, mark_dirty, rd_en;

  assign rd_en = (state == ST_IDLE) && up_valid;

  wbc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_set(up_addr[OFF_W +: SET_W]), .rd_tags(rd_tags),
    .look_set(req_set), .valid_row(valid_row), .dirty_row(dirty_row),
    .mark_dirty(mark_dirty), .mark_way(hit_way),
    .fill_en(fill_en), .fill_way(way_q), .fill_tag(req_tag), .fill_dirty(req_wr)
  );

  wbc_repl #(.SETS(SETS), .WAYS(WAYS), .POLICY(POLICY), .SET_W(SET_W), .WAY_W(WAY_W)) u_repl (
    .clk(clk), .rst(rst), .set_i(req_set),
    .touch_en(touch_en), .touch_way(touch_way), .victim(victim)
  );

  // lowest-numbered match and lowest-numbered hole
  always_comb begin
    hit = 1'b0; hit_way = '0; any_inv = 1'b0; inv_way = '0; hit_vec = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (valid_row[w] && rd_tags[w] == req_tag) begin
        hit = 1'b1; hit_way = WAY_W'(w); hit_vec[w] = 1'b1;
      end
      if (!valid_row[w]) begin
        any_inv = 1'b1; inv_way = WAY_W'(w);
      end
    end
  end

  assign alloc_way  = any_inv ? inv_way : victim;
  assign need_wb    = !any_inv && dirty_row[victim];
  assign fill_en    = (state == ST_WAIT) && dn_rd_done;
  assign mark_dirty = (state == ST_LOOK) && hit && req_wr;
  assign touch_en   = ((state == ST_LOOK) && hit) || fill_en;
  assign touch_way  = (state == ST_LOOK) ? hit_way : way_q;

  assign up_ready     = (state == ST_IDLE);
  assign dn_req_valid = (state == ST_WB) || (state == ST_FILL);
  assign dn_req_write = (state == ST_WB);
  assign dn_req_addr  = (state == ST_WB) ? {wb_tag_q, req_set} : {req_tag, req_set};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      req_tag <= '0; req_set <= '0; req_wr <= 1'b0;
      way_q <= '0; wb_tag_q <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0;
      ev_hit <= 1'b0; ev_miss <= 1'b0; ev_wb <= 1'b0; ev_fill <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      ev_hit <= 1'b0; ev_miss <= 1'b0; ev_wb <= 1'b0; ev_fill <= 1'b0;
      case (state)
        ST_IDLE: if (up_valid) begin
          req_tag <= up_addr[ADDR_W-1 -: TAG_W];
          req_set <= up_addr[OFF_W +: SET_W];
          req_wr  <= up_write;
          state   <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          rsp_valid <= 1'b1; rsp_hit <= 1'b1; ev_hit <= 1'b1;
          state <= ST_IDLE;
        end else begin
          ev_miss  <= 1'b1;
          way_q    <= alloc_way;
          wb_tag_q <= rd_tags[alloc_way];
          state    <= need_wb ? ST_WB : ST_FILL;
        end
        ST_WB: if (dn_req_ready) begin
          ev_wb <= 1'b1; state <= ST_FILL;
        end
        ST_FILL: if (dn_req_ready) begin
          ev_fill <= 1'b1; state <= ST_WAIT;
        end
        ST_WAIT: if (dn_rd_done) begin
          rsp_valid <= 1'b1; rsp_hit <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  wb_then_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && dn_req_write && dn_req_ready) |=> (dn_req_valid && !dn_req_write));
  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !$past(dn_req_valid));
  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK) |-> $onehot0(hit_vec));
  // R11
  stall_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    ev_miss |-> !up_ready);
  // R12
  hit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ev_hit |=> !ev_hit);
endmodule

// File: tb/wb_cache_ctrl_test.sv
`timescale 1ns/1ps
module wb_cache_ctrl_test;
  localparam int BLKW = 28;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, up_valid, up_write;
  logic [31:0] up_addr;
  logic [1:0] up_ready, rsp_valid, rsp_hit, dn_v, dn_w, dn_done;
  logic [1:0] ev_hit, ev_miss, ev_wb, ev_fill;
  logic [BLKW-1:0] dn_a [2];
  logic [1:0] pipe [2];

  wb_cache_ctrl #(.POLICY(0)) uut (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr),
    .up_ready(up_ready[0]), .rsp_valid(rsp_valid[0]), .rsp_hit(rsp_hit[0]),
    .dn_req_valid(dn_v[0]), .dn_req_write(dn_w[0]), .dn_req_addr(dn_a[0]),
    .dn_req_ready(1'b1), .dn_rd_done(dn_done[0]),
    .ev_hit(ev_hit[0]), .ev_miss(ev_miss[0]), .ev_wb(ev_wb[0]), .ev_fill(ev_fill[0]));

  wb_cache_ctrl #(.POLICY(1)) uut_plru (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr),
    .up_ready(up_ready[1]), .rsp_valid(rsp_valid[1]), .rsp_hit(rsp_hit[1]),
    .dn_req_valid(dn_v[1]), .dn_req_write(dn_w[1]), .dn_req_addr(dn_a[1]),
    .dn_req_ready(1'b1), .dn_rd_done(dn_done[1]),
    .ev_hit(ev_hit[1]), .ev_miss(ev_miss[1]), .ev_wb(ev_wb[1]), .ev_fill(ev_fill[1]));

  assign dn_done = {pipe[1][1], pipe[0][1]};

  logic lw [2][64];
  logic [BLKW-1:0] la [2][64];
  int nreq [2];
  int evh [2], evm [2], evw [2], evf [2];

  // downstream model: accepts at once, completes reads two cycles later
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        pipe[k] <= 2'b00;
      end else begin
        pipe[k] <= {pipe[k][0], dn_v[k] && !dn_w[k]};
        if (dn_v[k]) begin
          lw[k][nreq[k] % 64] = dn_w[k];
          la[k][nreq[k] % 64] = dn_a[k];
          nreq[k] = nreq[k] + 1;
        end
        if (ev_hit[k])  evh[k] = evh[k] + 1;
        if (ev_miss[k]) evm[k] = evm[k] + 1;
        if (ev_wb[k])   evw[k] = evw[k] + 1;
        if (ev_fill[k]) evf[k] = evf[k] + 1;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic r_hit [2];
  int r_nw [2], r_nr [2], r_base [2];

  localparam logic [23:0] T1 = 24'h00A001, T2 = 24'h00A002, T3 = 24'h00A003, T4 = 24'h00A004;
  localparam logic [23:0] T5 = 24'h00A005, T6 = 24'h00A006, T7 = 24'h00A007, T8 = 24'h00A008;

  function automatic logic [BLKW-1:0] blk(input logic [23:0] t, input logic [3:0] s);
    return {t, s};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one request on both instances; collects per-instance results
  task automatic access(input logic wr, input logic [23:0] t, input logic [3:0] s);
    bit got [2];
    bit busy_bad [2];
    int bh [2], bm [2], bw [2], bf [2];
    for (int k = 0; k < 2; k++) begin
      r_base[k] = nreq[k]; bh[k] = evh[k]; bm[k] = evm[k]; bw[k] = evw[k]; bf[k] = evf[k];
      got[k] = 0; busy_bad[k] = 0;
    end
    @(negedge clk);
    up_valid = 1'b1; up_write = wr; up_addr = {t, s, 4'h0};
    @(negedge clk);
    up_valid = 1'b0;
    for (int i = 0; i < 60 && !(got[0] && got[1]); i++) begin
      for (int k = 0; k < 2; k++) begin
        if (!got[k]) begin
          if (rsp_valid[k]) begin got[k] = 1; r_hit[k] = rsp_hit[k]; end
          else if (up_ready[k]) busy_bad[k] = 1;
        end
      end
      if (!(got[0] && got[1])) @(negedge clk);
    end
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      r_nw[k] = 0; r_nr[k] = 0;
      for (int j = r_base[k]; j < nreq[k]; j++) begin
        if (lw[k][j % 64]) r_nw[k]++; else r_nr[k]++;
      end
      check("R11 response arrived", int'(got[k]), 1);
      check("R11 no ready while busy", int'(busy_bad[k]), 0);
      check("R12 hit pulses", evh[k] - bh[k], int'(r_hit[k]));
      check("R12 miss pulses", evm[k] - bm[k], int'(!r_hit[k]));
      check("R12 wb pulses", evw[k] - bw[k], r_nw[k]);
      check("R12 fill pulses", evf[k] - bf[k], r_nr[k]);
    end
  endtask

  task automatic t_reset();
    check("R1 up_ready lru", int'(up_ready[0]), 1);
    check("R1 up_ready plru", int'(up_ready[1]), 1);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 dn_req_valid", int'(dn_v), 0);
  endtask

  task automatic t_cold_miss();
    access(1'b0, T1, 4'd0);
    check("R1 first access misses", int'(r_hit[0]), 0);
    check("R4 one read", r_nr[0], 1);
    check("R4 no write", r_nw[0], 0);
    check("R4 read address", int'(la[0][r_base[0] % 64]), int'(blk(T1, 4'd0)));
  endtask

  task automatic t_read_hit();
    access(1'b0, T1, 4'd0);
    check("R2 read hit", int'(r_hit[0]), 1);
    check("R2 no downstream", r_nw[0] + r_nr[0], 0);
  endtask

  task automatic t_write_hit();
    access(1'b1, T1, 4'd0);
    check("R3 write hit", int'(r_hit[0]), 1);
    check("R3 no downstream", r_nw[0] + r_nr[0], 0);
  endtask

  task automatic t_fill_ways();
    access(1'b0, T2, 4'd0);
    check("R6 fill w1 no evict", r_nw[0] * 10 + r_nr[0], 1);
    access(1'b0, T3, 4'd0);
    check("R6 fill w2 no evict", r_nw[0] * 10 + r_nr[0], 1);
    access(1'b0, T4, 4'd0);
    check("R6 fill w3 no evict", r_nw[0] * 10 + r_nr[0], 1);
    access(1'b0, T2, 4'd0);
    check("R6 T2 resident", int'(r_hit[0]), 1);
    access(1'b0, T3, 4'd0);
    check("R6 T3 resident", int'(r_hit[0]), 1);
    access(1'b0, T4, 4'd0);
    check("R6 T4 resident", int'(r_hit[0]), 1);
    access(1'b0, T1, 4'd0);
    check("R6 T1 resident", int'(r_hit[0]) + int'(r_hit[1]), 2);
  endtask

  task automatic t_policy();
    access(1'b0, T5, 4'd0);
    check("R8 T5 miss clean victim", r_nw[0] * 10 + r_nr[0], 1);
    check("R9 T5 miss clean victim", r_nw[1] * 10 + r_nr[1], 1);
    access(1'b0, T2, 4'd0);
    check("R8 LRU evicted T2", int'(r_hit[0]), 0);
    check("R9 PLRU kept T2", int'(r_hit[1]), 1);
  endtask

  task automatic t_dirty_evict();
    access(1'b0, T4, 4'd0);
    check("R8 T4 still resident", int'(r_hit[0]), 1);
    access(1'b0, T6, 4'd0);
    check("R7 two requests", r_nw[0] + r_nr[0], 2);
    check("R7 write first", int'(lw[0][r_base[0] % 64]), 1);
    check("R3 writeback of dirty T1", int'(la[0][r_base[0] % 64]), int'(blk(T1, 4'd0)));
    check("R7 read second", int'(lw[0][(r_base[0] + 1) % 64]), 0);
    check("R7 read address", int'(la[0][(r_base[0] + 1) % 64]), int'(blk(T6, 4'd0)));
  endtask

  task automatic t_write_miss();
    access(1'b1, T7, 4'd0);
    check("R5 write miss", int'(r_hit[0]), 0);
    check("R5 allocates by read", r_nw[0] * 10 + r_nr[0], 1);
    access(1'b0, T7, 4'd0);
    check("R5 allocated block hits", int'(r_hit[0]), 1);
    access(1'b0, T2, 4'd0);
    access(1'b0, T4, 4'd0);
    access(1'b0, T6, 4'd0);
    check("R8 T6 resident", int'(r_hit[0]), 1);
    access(1'b0, T8, 4'd0);
    check("R5 dirty write-miss line written back", r_nw[0], 1);
    check("R5 writeback address", int'(la[0][r_base[0] % 64]), int'(blk(T7, 4'd0)));
    check("R7 demand read after", int'(la[0][(r_base[0] + 1) % 64]), int'(blk(T8, 4'd0)));
  endtask

  task automatic t_sets();
    access(1'b0, T1, 4'd5);
    check("R10 other set misses", int'(r_hit[0]), 0);
    check("R10 no writeback", r_nw[0], 0);
    check("R10 read address", int'(la[0][r_base[0] % 64]), int'(blk(T1, 4'd5)));
    access(1'b0, T8, 4'd0);
    check("R10 set 0 untouched", int'(r_hit[0]), 1);
  endtask

  initial begin
    rst = 1'b1; up_valid = 1'b0; up_write = 1'b0; up_addr = '0;
    for (int k = 0; k < 2; k++) begin
      nreq[k] = 0; evh[k] = 0; evm[k] = 0; evw[k] = 0; evf[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_read_hit();
    t_write_hit();
    t_fill_ways();
    t_policy();
    t_dirty_evict();
    t_write_miss();
    t_sets();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule